// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on an idle-high line. It samples the line on a tick that runs at a fixed multiple of the bit rate and waits for a falling edge. It confirms a start bit by sampling again at the middle of that bit. It then shifts in eight data bits, least significant bit first, and can also take a parity bit. Last it checks the stop bit. The finished byte is loaded into a data holding register. Three sticky error flags (overrun, parity, framing) and a data-full flag report the result. Two interrupt outputs follow these flags while the interrupt enable is high.

The data holding register appears to the CPU as a valid/ready output. `dat_valid` is the data-full flag. A cycle with both `dat_valid` and `dat_ready` high consumes the byte and clears the flag. While `dat_valid` is high and `dat_ready` stays low, `dat_out` is held unchanged. That back-pressure does not stall the serial line: a frame that completes while the register is still full is an overrun. The overrun drops the new byte.

The three error types are handled differently. A parity or framing error still delivers its byte to `dat_out`, but does not raise `dat_valid`. Once any error flag is set, the receiver starts no new frame until all three error flags and the data-full flag are clear again.

Top module: `serial_rx_core`

## Requirements
- R1: After reset `dat_valid`, all three error flags and both interrupt outputs are 0.
- R2: A frame with correct parity (when enabled) and a stop bit of 1, finishing while `dat_valid` is 0, loads the byte into `dat_out` and sets `dat_valid`.
- R3: A cycle with `dat_valid` and `dat_ready` both 1 clears `dat_valid`; while `dat_valid` is 1 and `dat_ready` is 0, `dat_out` does not change.
- R4: A frame that finishes while `dat_valid` is 1 sets `err_ovr`, leaves `dat_out` at the old byte and keeps `dat_valid` at 1.
- R5: A parity mismatch sets `err_par`, copies the byte to `dat_out` and leaves `dat_valid` at 0.
- R6: A stop bit sampled as 0 sets `err_frm`, copies the byte to `dat_out` and leaves `dat_valid` at 0.
- R7: `irq_rx` equals `irq_en` AND `dat_valid`; `irq_err` equals `irq_en` AND the OR of the three error flags.
- R8: While any error flag is 1, and after that until the three error flags and `dat_valid` are all 0, a frame on the line is ignored: `dat_out`, `dat_valid` and the flags are not changed by it.
- R9: Each error flag has its own clear strobe (`clr_ovr`, `clr_par`, `clr_frm`), and a clear in the same cycle as a set leaves the flag at 0.
- R10: A low pulse that is no longer low at the eighth oversample is not a start bit; the receiver returns to idle and decodes later frames correctly.
- R11: With `par_en` 1 a parity bit follows D7; it is correct when the count of ones over data and parity is even (`par_odd` 0) or odd (`par_odd` 1). With `par_en` 0 the stop bit follows D7 and `err_par` is never set.
- R12: The first data bit after the start bit is bit 0 of `dat_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| irq_en | input | 1 | Receive interrupt enable |
| dat_ready | input | 1 | CPU read-and-clear strobe for the data register |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_par | input | 1 | Clear parity-error flag |
| clr_frm | input | 1 | Clear framing-error flag |
| dat_valid | output | 1 | Data-full flag |
| dat_out | output | 8 | Data holding register |
| err_ovr | output | 1 | Overrun flag |
| err_par | output | 1 | Parity-error flag |
| err_frm | output | 1 | Framing-error flag |
| irq_rx | output | 1 | Receive-complete interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The embedded assertions check the flag rules on every cycle. A clean frame must load and set the data-full flag. An errored frame must leave that flag low. An overrun must keep the held byte. A clear must win over a set. The held byte must stay stable under back-pressure, and the bit-timing machine must stay idle while the receiver is locked. Bit ordering, parity polarity, false-start rejection, the drop of the overrun byte and the full lock-release sequence depend on real serial waveforms, so only the bench scenarios show them at the ports.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic par_bad;
    logic stop_bad;
  } frame_err_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              lock_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output frame_err_t        err_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] START_CHK = CNT_W'(OSR/2 - 2);
  localparam logic [CNT_W-1:0] BIT_END   = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              parbit_q;
  logic              cfg_par_q;
  logic              cfg_odd_q;
  logic              done_q;
  frame_err_t        err_q;

  logic sample_now;
  assign sample_now = tick_i && (cnt_q == BIT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      parbit_q  <= 1'b0;
      cfg_par_q <= 1'b0;
      cfg_odd_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_i && !lock_i) begin
              state_q   <= ST_START;
              cnt_q     <= '0;
              cfg_par_q <= par_en_i;
              cfg_odd_q <= par_odd_i;
            end
          end
          ST_START: begin
            if (cnt_q == START_CHK) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (sample_now) begin
              cnt_q   <= '0;
              shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
              if (idx_q == LAST_IDX) begin
                idx_q   <= '0;
                state_q <= cfg_par_q ? ST_PAR : ST_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (sample_now) begin
              cnt_q    <= '0;
              parbit_q <= rx_i;
              state_q  <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (sample_now) begin
              cnt_q           <= '0;
              state_q         <= ST_IDLE;
              done_q          <= 1'b1;
              err_q.stop_bad  <= !rx_i;
              err_q.par_bad   <= cfg_par_q &&
                                 ((^shreg_q) ^ parbit_q ^ cfg_odd_q);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign byte_o = shreg_q;
  assign err_o  = err_q;

  // R8: a locked receiver never leaves idle
  assert_lock_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && lock_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  frame_err_t        err_i,
  input  logic              irq_en_i,
  input  logic              dat_ready_i,
  input  logic              clr_ovr_i,
  input  logic              clr_par_i,
  input  logic              clr_frm_i,
  output logic              lock_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o,
  output logic              par_o,
  output logic              frm_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, ovr_q, par_q, frm_q, lock_q;
  logic take, ovr_set, par_set, frm_set, full_set, full_clr, any_set, any_err;

  assign take     = done_i && !full_q;
  assign ovr_set  = done_i && full_q;
  assign par_set  = take && err_i.par_bad;
  assign frm_set  = take && err_i.stop_bad;
  assign full_set = take && !err_i.par_bad && !err_i.stop_bad;
  assign full_clr = dat_ready_i && full_q;
  assign any_set  = ovr_set || par_set || frm_set;
  assign any_err  = ovr_q || par_q || frm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      par_q  <= 1'b0;
      frm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (take) data_q <= byte_i;
      if (full_clr)      full_q <= 1'b0;
      else if (full_set) full_q <= 1'b1;
      if (clr_ovr_i)     ovr_q <= 1'b0;
      else if (ovr_set)  ovr_q <= 1'b1;
      if (clr_par_i)     par_q <= 1'b0;
      else if (par_set)  par_q <= 1'b1;
      if (clr_frm_i)     frm_q <= 1'b0;
      else if (frm_set)  frm_q <= 1'b1;
      lock_q <= any_set || (lock_q && (any_err || full_q));
    end
  end

  assign lock_o    = lock_q;
  assign full_o    = full_q;
  assign data_o    = data_q;
  assign ovr_o     = ovr_q;
  assign par_o     = par_q;
  assign frm_o     = frm_q;
  assign irq_rx_o  = irq_en_i && full_q;
  assign irq_err_o = irq_en_i && any_err;

  // R2: clean frame into an empty register loads it and marks it full
  assert_clean_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !full_q && !err_i.par_bad && !err_i.stop_bad)
      |=> (full_q && data_q == $past(byte_i)));
  // R3: held byte stays put under back-pressure
  assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !dat_ready_i) |=> $stable(data_q));
  // R4: overrun keeps the old byte and the full flag
  assert_overrun_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && full_q && !dat_ready_i) |=> (full_q && ovr_q && $stable(data_q)));
  // R5/R6: an errored frame leaves the full flag low
  assert_err_no_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !full_q && (err_i.par_bad || err_i.stop_bad)) |=> !full_q);
  // R9: clear wins over set
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr_i || clr_par_i || clr_frm_i) |=>
      ((!$past(clr_ovr_i) || !ovr_q) && (!$past(clr_par_i) || !par_q) &&
       (!$past(clr_frm_i) || !frm_q)));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              irq_en,
  input  logic              dat_ready,
  input  logic              clr_ovr,
  input  logic              clr_par,
  input  logic              clr_frm,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_out,
  output logic              err_ovr,
  output logic              err_par,
  output logic              err_frm,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              rx_s;
  logic              lock;
  logic              done;
  logic [DATA_W-1:0] rx_byte;
  frame_err_t        ferr;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_line), .q_o(rx_s)
  );

  srx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_s), .tick_i(os_tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .lock_i(lock),
    .done_o(done), .byte_o(rx_byte), .err_o(ferr)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done_i(done), .byte_i(rx_byte), .err_i(ferr),
    .irq_en_i(irq_en), .dat_ready_i(dat_ready),
    .clr_ovr_i(clr_ovr), .clr_par_i(clr_par), .clr_frm_i(clr_frm),
    .lock_o(lock), .full_o(dat_valid), .data_o(dat_out),
    .ovr_o(err_ovr), .par_o(err_par), .frm_o(err_frm),
    .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );
endmodule

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1, os_tick = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic irq_en = 1'b1, dat_ready = 1'b0;
  logic clr_ovr = 1'b0, clr_par = 1'b0, clr_frm = 1'b0;
  logic dat_valid, err_ovr, err_par, err_frm, irq_rx, irq_err;
  logic [7:0] dat_out;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic prev_valid = 1'b0;
  bit finished = 0;

  localparam int BIT_CLKS = 64;

  always #4 clk = ~clk;

  serial_rx_core dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en), .dat_ready(dat_ready),
    .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
    .dat_valid(dat_valid), .dat_out(dat_out), .err_ovr(err_ovr),
    .err_par(err_par), .err_frm(err_frm), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // oversampling tick: every 4th clock
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      os_tick = (t % 4 == 0);
    end
  end

  // scoreboard monitor: pops an expected byte at each rise of dat_valid
  initial begin
    forever begin
      @(negedge clk);
      if (dat_valid && !prev_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", dat_out, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(dat_out == e, "R2/R12 delivered byte", dat_out, e);
        end
      end
      prev_valid = dat_valid;
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit stop_v);
    rx_line = 1'b0; wait_clks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i]; wait_clks(BIT_CLKS);
    end
    if (par_en) begin
      rx_line = (^b) ^ par_odd ^ bad_par; wait_clks(BIT_CLKS);
    end
    rx_line = stop_v; wait_clks(BIT_CLKS);
    rx_line = 1'b1; wait_clks(BIT_CLKS);
  endtask

  task automatic read_byte;
    dat_ready = 1'b1; wait_clks(1); dat_ready = 1'b0; wait_clks(1);
    chk(dat_valid == 1'b0, "R3 read clears valid", dat_valid, 0);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wait_clks(1); s = 1'b0; wait_clks(1);
  endtask

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    chk(!dat_valid && !err_ovr && !err_par && !err_frm, "R1 flags", {dat_valid, err_ovr, err_par, err_frm}, 0);
    chk(!irq_rx && !irq_err, "R1 irqs", {irq_rx, irq_err}, 0);

    // clean frame, no parity
    exp_q.push_back(8'hA5); send_frame(8'hA5, 0, 1);
    chk(dat_valid, "R2 valid set", dat_valid, 1);
    chk(irq_rx && !irq_err, "R7 irq_rx", {irq_rx, irq_err}, 2);
    read_byte();
    // back-pressure
    exp_q.push_back(8'h3C); send_frame(8'h3C, 0, 1);
    wait_clks(200);
    chk(dat_valid && dat_out == 8'h3C, "R3 held", dat_out, 8'h3C);
    read_byte();
    // LSB first
    exp_q.push_back(8'h01); send_frame(8'h01, 0, 1);
    chk(dat_out == 8'h01, "R12 bit order", dat_out, 8'h01);
    read_byte();
    // parity modes
    par_en = 1'b1; par_odd = 1'b0;
    exp_q.push_back(8'h96); send_frame(8'h96, 0, 1);
    chk(dat_valid && !err_par, "R11 even parity", err_par, 0);
    read_byte();
    par_odd = 1'b1;
    exp_q.push_back(8'h7E); send_frame(8'h7E, 0, 1);
    chk(dat_valid && !err_par, "R11 odd parity", err_par, 0);
    read_byte();
    // parity error
    send_frame(8'h5A, 1, 1);
    chk(err_par && !dat_valid, "R5 parity flag", {err_par, dat_valid}, 2);
    chk(dat_out == 8'h5A, "R5 byte delivered", dat_out, 8'h5A);
    chk(irq_err && !irq_rx, "R7 irq_err", {irq_err, irq_rx}, 2);
    // locked while error set
    send_frame(8'hC3, 0, 1);
    chk(dat_out == 8'h5A && !dat_valid && !err_ovr, "R8 ignored while locked", dat_out, 8'h5A);
    pulse(clr_par);
    chk(!err_par && !irq_err, "R9 parity clear", err_par, 0);
    // framing error, parity off
    par_en = 1'b0;
    send_frame(8'h66, 0, 0);
    chk(err_frm && !dat_valid && dat_out == 8'h66, "R6 framing", dat_out, 8'h66);
    chk(!err_par, "R11 no parity error when disabled", err_par, 0);
    pulse(clr_frm);
    chk(!err_frm, "R9 framing clear", err_frm, 0);
    // overrun
    exp_q.push_back(8'h11); send_frame(8'h11, 0, 1);
    send_frame(8'h22, 0, 1);
    chk(err_ovr && dat_valid && dat_out == 8'h11, "R4 overrun", dat_out, 8'h11);
    pulse(clr_ovr);
    send_frame(8'h33, 0, 1);
    chk(!err_ovr && dat_out == 8'h11, "R8 locked until full cleared", dat_out, 8'h11);
    read_byte();
    exp_q.push_back(8'h44); send_frame(8'h44, 0, 1);
    chk(dat_valid && dat_out == 8'h44, "R8 reception restarts", dat_out, 8'h44);
    read_byte();
    // clear wins over set
    par_en = 1'b1; par_odd = 1'b0;
    clr_par = 1'b1; send_frame(8'h99, 1, 1); clr_par = 1'b0; wait_clks(1);
    chk(!err_par && dat_out == 8'h99, "R9 clear priority", err_par, 0);
    // false start
    rx_line = 1'b0; wait_clks(12); rx_line = 1'b1; wait_clks(3 * BIT_CLKS);
    chk(!dat_valid && dat_out == 8'h99 && !err_frm, "R10 glitch ignored", dat_out, 8'h99);
    exp_q.push_back(8'hE7); send_frame(8'hE7, 0, 1);
    chk(dat_valid && dat_out == 8'hE7, "R10 decode after glitch", dat_out, 8'hE7);
    read_byte();
    // interrupt gating
    irq_en = 1'b0;
    exp_q.push_back(8'h5C); send_frame(8'h5C, 0, 1);
    chk(dat_valid && !irq_rx, "R7 irq masked", irq_rx, 0);
    read_byte();
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule